// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between one narrow port and a wide port made of two equal halves, all on a single clock. Going from narrow to wide, two narrow words that arrive on consecutive cycles are captured. They then appear together on the two halves. The lower half sits behind a two-register pipeline and the upper half behind a single register, so the first word has moved one stage further by the time the second word is captured beside it.

Going from wide to narrow, each half is captured in its own register. A select line then decides which registered half drives the narrow port.

All storage loads only while its active-low load enable is low. The select line and both active-low output enables are sampled on the clock, so a change in direction or selection takes effect one edge later. Each three-state output is modelled as a data bus plus a one-bit drive flag. The data bus always shows the register contents, and the flag says whether the pad would drive.

Top module: `nwx_bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data register clears to zero, `a_drive` and `b_drive` go low, and the registered select points at the lower half. After that edge, `a_out`, `b1_out` and `b2_out` read zero.
- R2: At each edge where `lo_load_n` is low, the first lower-half stage takes `a_in` and `b1_out` takes the previous content of that first stage. As a result, `b1_out` shows the word loaded two lower-half loads earlier. While `lo_load_n` is high, both stages hold.
- R3: At an edge where `hi_load_n` is low, `b2_out` takes `a_in`. While `hi_load_n` is high, `b2_out` holds.
- R4: Word W0 is applied with only `lo_load_n` low, and word W1 is applied on the next edge with both load enables low. After that second edge, `b1_out` = W0 and `b2_out` = W1 at the same time.
- R5: At an edge where `ret1_load_n` is low, the lower-half return register takes `b1_in`. At an edge where `ret2_load_n` is low, the upper-half return register takes `b2_in`. While its enable is high, each return register holds.
- R6: `sel_hi` is registered on every edge. When the registered value is 0, `a_out` shows the lower-half return register; when it is 1, `a_out` shows the upper-half return register. A change of `sel_hi` is therefore seen on `a_out` one edge later.
- R7: Outside reset, `a_drive` equals the inverse of `oe_a_n` sampled at the previous edge, and `b_drive` equals the inverse of `oe_b_n` sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | NW | Narrow-port input data |
| lo_load_n | input | 1 | Active-low load for both lower-half capture stages |
| hi_load_n | input | 1 | Active-low load for the upper-half capture register |
| b1_in | input | NW | Lower-half wide-port input data |
| b2_in | input | NW | Upper-half wide-port input data |
| ret1_load_n | input | 1 | Active-low load for the lower-half return register |
| ret2_load_n | input | 1 | Active-low load for the upper-half return register |
| sel_hi | input | 1 | Narrow-port source: 0 = lower half, 1 = upper half (registered) |
| oe_a_n | input | 1 | Active-low narrow-port output enable (registered) |
| oe_b_n | input | 1 | Active-low wide-port output enable (registered) |
| a_out | output | NW | Narrow-port output data |
| a_drive | output | 1 | Narrow-port pad drive flag |
| b1_out | output | NW | Lower-half output data |
| b2_out | output | NW | Upper-half output data |
| b_drive | output | 1 | Wide-port pad drive flag, shared by both halves |

## Verification
The bench builds the block with its default narrow width of 12 and a lower-half depth of 2. This is the exact geometry in which two consecutive words pair up on the wide port. With it, the pairing sequence, the hold behaviour of each enable, and the one-edge lag of the select and the drive flags can all be checked directly. Random stimulus toggles every load enable, the select and both output enables independently. This covers interleavings such as lower-half-only loads, an upper-half load without a lower-half load, and a select change in the same cycle as a return-register load.

// File: rtl/nwx_pkg.sv
package nwx_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  function automatic logic is_on(input logic en_n);
    return ~en_n;
  endfunction

  function automatic half_sel_e to_half(input logic sel_bit);
    return sel_bit ? HALF_HI : HALF_LO;
  endfunction

endpackage

// File: rtl/nwx_a2b_path.sv
module nwx_a2b_path #(
  parameter int NW       = 12,
  parameter int LO_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] a_in,
  input  logic          lo_load_n,
  input  logic          hi_load_n,
  output logic [NW-1:0] lo_word,
  output logic [NW-1:0] hi_word,
  output logic [NW-1:0] lo_head,
  output logic          lo_load,
  output logic          hi_load
);
  import nwx_pkg::*;

  localparam int LAST = LO_DEPTH - 1;

  logic [NW-1:0] stg [LO_DEPTH];
  logic [NW-1:0] hi_q;

  assign lo_load = is_on(lo_load_n);
  assign hi_load = is_on(hi_load_n);

  for (genvar i = 0; i < LO_DEPTH; i++) begin : g_lo_stage
    logic [NW-1:0] feed;
    if (i == 0) begin : g_head
      assign feed = a_in;
    end else begin : g_body
      assign feed = stg[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst)          stg[i] <= '0;
      else if (lo_load) stg[i] <= feed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          hi_q <= '0;
    else if (hi_load) hi_q <= a_in;
  end

  assign lo_head = stg[0];
  assign lo_word = stg[LAST];
  assign hi_word = hi_q;
endmodule

// File: rtl/nwx_b2a_path.sv
module nwx_b2a_path #(
  parameter int NW = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NW-1:0]      b1_in,
  input  logic [NW-1:0]      b2_in,
  input  logic               ret1_load_n,
  input  logic               ret2_load_n,
  input  nwx_pkg::half_sel_e sel_q,
  output logic [NW-1:0]      a_word,
  output logic [NW-1:0]      ret1,
  output logic [NW-1:0]      ret2
);
  import nwx_pkg::*;

  function automatic logic [NW-1:0] pick_half(input half_sel_e s,
                                              input logic [NW-1:0] lo,
                                              input logic [NW-1:0] hi);
    return (s == HALF_HI) ? hi : lo;
  endfunction

  logic [NW-1:0] r1_q, r2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_q <= '0;
      r2_q <= '0;
    end else begin
      if (is_on(ret1_load_n)) r1_q <= b1_in;
      if (is_on(ret2_load_n)) r2_q <= b2_in;
    end
  end

  assign ret1   = r1_q;
  assign ret2   = r2_q;
  assign a_word = pick_half(sel_q, r1_q, r2_q);
endmodule

// File: rtl/nwx_dir_ctl.sv
module nwx_dir_ctl (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_hi,
  input  logic               oe_a_n,
  input  logic               oe_b_n,
  output nwx_pkg::half_sel_e sel_q,
  output logic               a_drive,
  output logic               b_drive
);
  import nwx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= HALF_LO;
      a_drive <= 1'b0;
      b_drive <= 1'b0;
    end else begin
      sel_q   <= to_half(sel_hi);
      a_drive <= is_on(oe_a_n);
      b_drive <= is_on(oe_b_n);
    end
  end
endmodule

// File: rtl/nwx_bus_exchanger.sv
module nwx_bus_exchanger #(
  parameter int NW       = 12,
  parameter int LO_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] a_in,
  input  logic          lo_load_n,
  input  logic          hi_load_n,
  input  logic [NW-1:0] b1_in,
  input  logic [NW-1:0] b2_in,
  input  logic          ret1_load_n,
  input  logic          ret2_load_n,
  input  logic          sel_hi,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  output logic [NW-1:0] a_out,
  output logic          a_drive,
  output logic [NW-1:0] b1_out,
  output logic [NW-1:0] b2_out,
  output logic          b_drive
);
  import nwx_pkg::*;

  half_sel_e     sel_q;
  logic [NW-1:0] lo_head;
  logic [NW-1:0] ret1, ret2;
  logic          lo_load, hi_load;

  nwx_a2b_path #(.NW(NW), .LO_DEPTH(LO_DEPTH)) u_a2b (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .lo_load_n(lo_load_n),
    .hi_load_n(hi_load_n),
    .lo_word  (b1_out),
    .hi_word  (b2_out),
    .lo_head  (lo_head),
    .lo_load  (lo_load),
    .hi_load  (hi_load)
  );

  nwx_b2a_path #(.NW(NW)) u_b2a (
    .clk        (clk),
    .rst        (rst),
    .b1_in      (b1_in),
    .b2_in      (b2_in),
    .ret1_load_n(ret1_load_n),
    .ret2_load_n(ret2_load_n),
    .sel_q      (sel_q),
    .a_word     (a_out),
    .ret1       (ret1),
    .ret2       (ret2)
  );

  nwx_dir_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .sel_hi (sel_hi),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .sel_q  (sel_q),
    .a_drive(a_drive),
    .b_drive(b_drive)
  );
endmodule

// File: rtl/nwx_checker.sv
module nwx_checker #(
  parameter int NW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] a_in,
  input logic [NW-1:0] b1_in,
  input logic [NW-1:0] b2_in,
  input logic          sel_hi,
  input logic          ret1_load_n,
  input logic          ret2_load_n,
  input logic          oe_a_n,
  input logic          oe_b_n,
  input logic          lo_load,
  input logic          hi_load,
  input logic [NW-1:0] lo_head,
  input logic [NW-1:0] a_out,
  input logic [NW-1:0] b1_out,
  input logic [NW-1:0] b2_out,
  input logic          a_drive,
  input logic          b_drive
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!a_drive && !b_drive && a_out == '0 && b1_out == '0 && b2_out == '0));

  a_r2_lo_shift: assert property (@(posedge clk) disable iff (rst)
    lo_load |=> (b1_out == $past(lo_head)));

  a_r2_lo_hold: assert property (@(posedge clk) disable iff (rst)
    !lo_load |=> $stable(b1_out));

  a_r3_hi_load: assert property (@(posedge clk) disable iff (rst)
    hi_load |=> (b2_out == $past(a_in)));

  a_r3_hi_hold: assert property (@(posedge clk) disable iff (rst)
    !hi_load |=> $stable(b2_out));

  a_r6_sel_lo: assert property (@(posedge clk) disable iff (rst)
    (!ret1_load_n && !sel_hi) |=> (a_out == $past(b1_in)));

  a_r6_sel_hi: assert property (@(posedge clk) disable iff (rst)
    (!ret2_load_n && sel_hi) |=> (a_out == $past(b2_in)));

  a_r7_a_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_drive == !$past(oe_a_n)));

  a_r7_b_drive: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b_drive == !$past(oe_b_n)));
endmodule

bind nwx_bus_exchanger nwx_checker #(.NW(NW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_in       (a_in),
  .b1_in      (b1_in),
  .b2_in      (b2_in),
  .sel_hi     (sel_hi),
  .ret1_load_n(ret1_load_n),
  .ret2_load_n(ret2_load_n),
  .oe_a_n     (oe_a_n),
  .oe_b_n     (oe_b_n),
  .lo_load    (lo_load),
  .hi_load    (hi_load),
  .lo_head    (lo_head),
  .a_out      (a_out),
  .b1_out     (b1_out),
  .b2_out     (b2_out),
  .a_drive    (a_drive),
  .b_drive    (b_drive)
);

// File: tb/test_nwx_bus_exchanger.sv
module test_nwx_bus_exchanger;
  localparam int NW = 12;

  logic clk = 1'b0;
  logic rst;
  logic [NW-1:0] a_in, b1_in, b2_in;
  logic lo_load_n, hi_load_n, ret1_load_n, ret2_load_n, sel_hi, oe_a_n, oe_b_n;
  logic [NW-1:0] a_out, b1_out, b2_out;
  logic a_drive, b_drive;

  always #4ns clk = ~clk;

  nwx_bus_exchanger #(.NW(NW), .LO_DEPTH(2)) i_nwx_bus_exchanger (
    .clk(clk), .rst(rst), .a_in(a_in), .lo_load_n(lo_load_n), .hi_load_n(hi_load_n),
    .b1_in(b1_in), .b2_in(b2_in), .ret1_load_n(ret1_load_n), .ret2_load_n(ret2_load_n),
    .sel_hi(sel_hi), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .a_out(a_out), .a_drive(a_drive),
    .b1_out(b1_out), .b2_out(b2_out), .b_drive(b_drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [NW-1:0] m_lo[$];
  logic [NW-1:0] m_hi, m_r1, m_r2;
  bit m_sel, m_ad, m_bd;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_lo = '{0, 0};
      m_hi = 0; m_r1 = 0; m_r2 = 0;
      m_sel = 0; m_ad = 0; m_bd = 0;
    end else begin
      if (!lo_load_n) begin
        m_lo.push_back(a_in);
        void'(m_lo.pop_front());
      end
      if (!hi_load_n)   m_hi = a_in;
      if (!ret1_load_n) m_r1 = b1_in;
      if (!ret2_load_n) m_r2 = b2_in;
      m_sel = sel_hi;
      m_ad  = !oe_a_n;
      m_bd  = !oe_b_n;
    end
  endtask

  task automatic compare_all();
    check("R2 b1_out", int'(b1_out), int'(m_lo[0]));
    check("R3 b2_out", int'(b2_out), int'(m_hi));
    check("R6 a_out", int'(a_out), int'(m_sel ? m_r2 : m_r1));
    check("R7 a_drive", int'(a_drive), int'(m_ad));
    check("R7 b_drive", int'(b_drive), int'(m_bd));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    lo_load_n = 1; hi_load_n = 1; ret1_load_n = 1; ret2_load_n = 1;
    oe_a_n = 1; oe_b_n = 1; sel_hi = 0;
  endtask

  initial begin
    rst = 1; a_in = '1; b1_in = '1; b2_in = '1;
    idle();
    tick(); tick();
    // R1: reset state
    check("R1 a_out", int'(a_out), 0);
    check("R1 b1_out", int'(b1_out), 0);
    check("R1 b2_out", int'(b2_out), 0);
    check("R1 drives", int'({a_drive, b_drive}), 0);
    rst = 0;
    tick();

    // R4: pairing of two consecutive narrow words
    a_in = 12'hA5C; lo_load_n = 0; tick();
    a_in = 12'h3B7; hi_load_n = 0; tick();
    idle(); a_in = 12'hFFF; tick();
    check("R4 pair lo", int'(b1_out), 12'hA5C);
    check("R4 pair hi", int'(b2_out), 12'h3B7);

    // R5 R6: return registers, select lag
    b1_in = 12'h111; b2_in = 12'h222; ret1_load_n = 0; ret2_load_n = 0; tick();
    idle(); b1_in = 12'h999; b2_in = 12'h888; sel_hi = 1;
    check("R5 ret lo seen", int'(a_out), 12'h111);
    tick();
    check("R6 sel hi", int'(a_out), 12'h222);
    sel_hi = 1; tick();
    check("R5 ret hold", int'(a_out), 12'h222);

    // R7: drive flags
    oe_a_n = 0; oe_b_n = 1; tick();
    check("R7 a on", int'({a_drive, b_drive}), 2);
    oe_a_n = 1; oe_b_n = 0; tick();
    check("R7 b on", int'({a_drive, b_drive}), 1);

    // random interleavings
    for (int i = 0; i < 2000; i++) begin
      a_in = NW'($urandom); b1_in = NW'($urandom); b2_in = NW'($urandom);
      lo_load_n = 1'($urandom); hi_load_n = 1'($urandom);
      ret1_load_n = 1'($urandom); ret2_load_n = 1'($urandom);
      sel_hi = 1'($urandom); oe_a_n = 1'($urandom); oe_b_n = 1'($urandom);
      rst = ($urandom_range(0, 199) == 0);
      tick();
    end
    rst = 1; tick();
    check("R1 late reset", int'({a_out, b1_out, b2_out, a_drive, b_drive}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule